// File: doc/BRIEF.md
# I2C Master Clock Generator with Bus Synchronization

This block produces the serial clock of an I2C master on a wired-AND line. It never drives the line high. It only enables a pull-down (`scl_pull`) for the low phase of each clock, and then releases the line. It times the high phase only from the first cycle in which the sampled line (`scl_in`) is actually high. A new low phase starts whenever the line is seen low, whichever device pulled it down. As a result, when several masters share the line, the high time is set by the master with the shortest high phase and the low time by the master with the longest low phase. Slaves can also stretch the clock by holding the line low.

The half period is a whole number of system clocks, chosen by `rate_sel` as `HALF_BASE << rate_sel`. The default gives 4, 8, 16 or 32 clocks. The block is idle whenever the controller is not in a master mode. While the serial interrupt flag is set, the block extends the low phase indefinitely, so software can handshake after each acknowledged byte. Two strobes mark the bit phases for the shift logic: `rise_stb` marks the start of a high phase and `fall_stb` marks the end of one.

The block has four states:
- IDLE: line released.
- LOW: pull-down on, counting the low phase.
- HWAIT: line released, waiting until the line is seen high.
- HIGH: line released, counting the high phase.

The transitions are:
- Any state goes to IDLE when `master_en` is low.
- IDLE goes to LOW when `master_en` is high.
- LOW goes to HWAIT when the count ends and `irq_flag` is low.
- HWAIT goes to HIGH when `scl_in` is high.
- HIGH goes to LOW when the count ends or when `scl_in` is seen low.

Top module: `scl_clkgen`

## Requirements
- R1: While `master_en` is low, `scl_pull`, `rise_stb` and `fall_stb` are 0 from the cycle after `master_en` is sampled low, and they are 0 after reset.
- R2: The half period H equals `HALF_BASE << rate_sel` system clocks (4, 8, 16, 32 for `rate_sel` 0 to 3 with defaults).
- R3: With no other device on the line, `scl_pull` is 1 for exactly H cycles and then 0 for exactly H cycles, repeating (50% duty).
- R4: If the line is seen low during the block's high phase, `fall_stb` is 1 in that cycle, and a full H-cycle low phase with `scl_pull` = 1 starts in the next cycle.
- R5: If another device holds the line low after the block releases it, `scl_pull` stays 0. The high phase then lasts H cycles, counted from the first cycle in which `scl_in` is 1.
- R6: While `irq_flag` is 1 at the end of a low phase, `scl_pull` stays 1. It drops in the cycle after `irq_flag` is sampled 0.
- R7: When `master_en` rises, `scl_pull` becomes 1 in the next cycle and the first low phase lasts H cycles.
- R8: `rise_stb` is 1 in the first cycle of each high phase, in which `scl_in` is 1 and `scl_pull` is 0. `rise_stb` and `fall_stb` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | RATE_W | Half-period select, H = HALF_BASE << rate_sel |
| master_en | input | 1 | 1 while the controller is in a master mode |
| scl_in | input | 1 | Synchronized sample of the clock line |
| irq_flag | input | 1 | Serial interrupt flag; extends the low phase while set |
| scl_pull | output | 1 | 1 enables the clock-line pull-down |
| rise_stb | output | 1 | Pulse on the first cycle of a high phase |
| fall_stb | output | 1 | Pulse on the cycle a high phase ends |

## Verification
A wrong phase count shows at the ports within one half period, as a low or high run of `scl_pull` longer or shorter than H. A state stuck in HWAIT or LOW shows as a line that never toggles. Missed synchronization shows within one bit. For example, a block that does not restart on an external fall keeps its pull-down off for the rest of its own high count. A block that counts its high phase before the line rises produces a high time shorter than H after a stretch. The sweep covers every rate with runs of both phases. Directed cases cover external falls, external stretches and the interrupt hold.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_HWAIT = 2'd2,
        ST_HIGH  = 2'd3
    } scl_state_e;
endpackage

// File: rtl/scl_rate_dec.sv
module scl_rate_dec #(
    parameter int RATE_W    = 2,
    parameter int HALF_BASE = 4,
    parameter int CNT_W     = 6
) (
    input  logic [RATE_W-1:0] rate_sel,
    output logic [CNT_W-1:0]  half
);
    localparam int NRATE = 1 << RATE_W;

    logic [CNT_W-1:0] table_q [NRATE];

    // R2: each entry is the base half period shifted by its index
    for (genvar g = 0; g < NRATE; g++) begin : g_rate
        assign table_q[g] = CNT_W'(HALF_BASE << g);
    end

    assign half = table_q[rate_sel];
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld_one,
    input  logic             inc,
    input  logic [CNT_W-1:0] half,
    output logic             at_last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (ld_one) cnt_q <= CNT_W'(1);
        else if (inc)    cnt_q <= cnt_q + CNT_W'(1);
    end

    // >= keeps the phase finite if the rate drops mid-phase
    assign at_last = (cnt_q >= (half - CNT_W'(1)));
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_clkgen_pkg::*;
#(
    parameter int RATE_W    = 2,
    parameter int HALF_BASE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              master_en,
    input  logic              scl_in,
    input  logic              irq_flag,
    output logic              scl_pull,
    output logic              rise_stb,
    output logic              fall_stb
);
    localparam int MAX_HALF = HALF_BASE << ((1 << RATE_W) - 1);
    localparam int CNT_W    = $clog2(MAX_HALF) + 1;

    scl_state_e       state_q, state_d;
    logic [CNT_W-1:0] half;
    logic             at_last;
    logic             clr, ld_one, inc;

    scl_rate_dec #(
        .RATE_W    (RATE_W),
        .HALF_BASE (HALF_BASE),
        .CNT_W     (CNT_W)
    ) u_rate (
        .rate_sel (rate_sel),
        .half     (half)
    );

    scl_phase_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .ld_one  (ld_one),
        .inc     (inc),
        .half    (half),
        .at_last (at_last)
    );

    // Next state and counter control
    always_comb begin
        state_d = state_q;
        clr     = 1'b0;
        ld_one  = 1'b0;
        inc     = 1'b0;
        if (!master_en) begin
            state_d = ST_IDLE;
            clr     = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_LOW;
                    clr     = 1'b1;
                end
                ST_LOW: begin
                    if (at_last) begin
                        if (!irq_flag) begin
                            state_d = ST_HWAIT;
                            clr     = 1'b1;
                        end
                    end else begin
                        inc = 1'b1;
                    end
                end
                ST_HWAIT: begin
                    if (scl_in) begin
                        state_d = ST_HIGH;
                        ld_one  = 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (!scl_in || at_last) begin
                        state_d = ST_LOW;
                        clr     = 1'b1;
                    end else begin
                        inc = 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    clr     = 1'b1;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        scl_pull = 1'b0;
        rise_stb = 1'b0;
        fall_stb = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_LOW:   scl_pull = 1'b1;
            ST_HWAIT: rise_stb = master_en && scl_in;
            ST_HIGH:  fall_stb = master_en && (!scl_in || at_last);
            default:  ;
        endcase
    end
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk #(
    parameter int RATE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RATE_W-1:0] rate_sel,
    input logic              master_en,
    input logic              scl_in,
    input logic              irq_flag,
    input logic              scl_pull,
    input logic              rise_stb,
    input logic              fall_stb
);
    a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (!scl_pull && !rise_stb && !fall_stb));

    a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && scl_pull && irq_flag) |=> scl_pull);

    a_r4_fall_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && fall_stb) |=> scl_pull);

    a_r8_rise_released: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> !scl_pull);

    a_r8_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_stb, fall_stb}));

    a_r7_enable_pulls: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master_en) |=> scl_pull);
endmodule

bind scl_clkgen scl_clkgen_chk #(.RATE_W(RATE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .master_en (master_en),
    .scl_in    (scl_in),
    .irq_flag  (irq_flag),
    .scl_pull  (scl_pull),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb)
);

// File: tb/scl_clkgen_tb.sv
`timescale 1ns/1ps
module scl_clkgen_tb;
    localparam int RATE_W    = 2;
    localparam int HALF_BASE = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [RATE_W-1:0] rate_sel = '0;
    logic              master_en = 1'b0;
    logic              irq_flag = 1'b0;
    logic              ext_pull = 1'b0;
    logic              scl_in;
    logic              scl_pull, rise_stb, fall_stb;
    int                checks = 0;
    int                errors = 0;

    always #5 clk = ~clk;

    // wired-AND line model
    assign scl_in = !(scl_pull || ext_pull);

    scl_clkgen #(.RATE_W(RATE_W), .HALF_BASE(HALF_BASE)) u_dut (
        .clk (clk), .rst_n (rst_n), .rate_sel (rate_sel),
        .master_en (master_en), .scl_in (scl_in), .irq_flag (irq_flag),
        .scl_pull (scl_pull), .rise_stb (rise_stb), .fall_stb (fall_stb)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_pull(input logic v);
        for (int i = 0; i < 1000 && scl_pull != v; i++) tick();
    endtask

    task automatic run_len(input logic v, output int n);
        n = 0;
        while (scl_pull == v && n < 1000) begin
            n++;
            tick();
        end
    endtask

    initial begin
        int n;
        int h;
        repeat (3) tick();
        check("R1 reset pull", scl_pull, 0);
        check("R1 reset strobes", rise_stb | fall_stb, 0);
        rst_n = 1'b1;
        repeat (2) tick();

        // R2/R3/R7 sweep over every rate
        for (int r = 0; r < (1 << RATE_W); r++) begin
            h = HALF_BASE << r;
            master_en = 1'b0;
            repeat (3) tick();
            rate_sel = RATE_W'(r);
            master_en = 1'b1;
            tick();
            check("R7 pull after enable", scl_pull, 1);
            for (int p = 0; p < 2; p++) begin
                run_len(1'b1, n);
                check("R2 R3 R7 low length", n, h);
                check("R8 rise at high start", rise_stb, 1);
                run_len(1'b0, n);
                check("R2 R3 high length", n, h);
            end
        end

        // R4: external fall during high phase, rate 1
        h = HALF_BASE << 1;
        rate_sel = 2'd1;
        wait_pull(1'b0);
        tick();
        ext_pull = 1'b1;
        #1;
        check("R4 fall strobe", fall_stb, 1);
        check("R8 no rise with fall", rise_stb, 0);
        tick();
        ext_pull = 1'b0;
        #1;
        run_len(1'b1, n);
        check("R4 low after external fall", n, h);

        // R5: external stretch after release
        wait_pull(1'b1);
        wait_pull(1'b0);
        ext_pull = 1'b1;
        #1;
        for (int i = 0; i < 5; i++) begin
            tick();
            check("R5 no pull while stretched", scl_pull, 0);
        end
        ext_pull = 1'b0;
        #1;
        check("R5 R8 rise after stretch", rise_stb, 1);
        n = 0;
        while (scl_in && !scl_pull && n < 1000) begin
            n++;
            tick();
        end
        check("R5 high counted from rise", n, h);

        // R6: interrupt flag extends low phase
        wait_pull(1'b0);
        irq_flag = 1'b1;
        wait_pull(1'b1);
        repeat (3 * h) tick();
        check("R6 held while flag set", scl_pull, 1);
        irq_flag = 1'b0;
        #1;
        check("R6 still held same cycle", scl_pull, 1);
        tick();
        check("R6 released after clear", scl_pull, 0);

        // R1: leave master mode during a low phase
        wait_pull(1'b1);
        master_en = 1'b0;
        tick();
        check("R1 release on disable", scl_pull, 0);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            n += int'(scl_pull) + int'(rise_stb) + int'(fall_stb);
        end
        check("R1 quiet while disabled", n, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule